// File: doc/BRIEF.md
# Bridge Cycle-by-Cycle Current Limiter

This block guards one H-bridge against excess load current. Each clock cycle may carry a digital sample made of a high-side current code, a low-side current code and a junction-temperature code. When the high-side current reaches the limit threshold, the block raises `force_off` for a fixed off-time. The bridge drive logic downstream tri-states the outputs while `force_off` is high and resumes normal switching when it falls. A minimum spacing between limit events keeps the switching rate that the limiter causes at or below 20 kHz.

The limit threshold is nominal up to a knee temperature. Above the knee it falls linearly to a floor value at an end temperature. Above the end temperature the block raises an overtemperature request. A sample whose high-side or low-side current meets its hard-short threshold raises a one-cycle short request. That detection is masked for a blanking window that restarts on every output-transition strobe. Latching and clearing of faults belong to a neighbouring block.

Samples enter as a stream qualified by `samp_valid`. There is no ready signal: the block accepts a sample in every cycle, so it never applies back-pressure. When `samp_valid` is low, the sample inputs are ignored. Durations are parameters given in nanoseconds and are converted to cycles with the clock-frequency parameter `CLK_MHZ`. Current codes are in units of 1/16 A and temperature codes in units of 1 °C.

Top module: `hb_current_limiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `force_off`, `short_req` and `ot_req` are all low.
- R2: At a temperature code of 160 or below, the limit threshold is 104 (6.5 A). A valid sample with `hs_cur` >= 104 triggers a limit event, and a sample with `hs_cur` = 103 does not.
- R3: For a temperature code t with 160 < t < 175, the threshold is 104 - floor(64*(t-160)/15). For t >= 175, the threshold is 40 (2.5 A).
- R4: A limit event accepted at clock edge k holds `force_off` high for exactly OFF_CYC = CLK_MHZ*20000/1000 cycles, starting in the cycle after edge k.
- R5: An over-limit sample that arrives while `force_off` is high is ignored and does not lengthen the off-time.
- R6: Two accepted limit events are at least PER_CYC = CLK_MHZ*50000/1000 cycles apart (a 50 µs period, which is 20 kHz). An over-limit sample PER_CYC-1 cycles after an accepted event is ignored, and one at PER_CYC cycles is accepted.
- R7: A valid, unmasked sample with `hs_cur` >= 176 (11 A) or `ls_cur` >= 128 (8 A) drives `short_req` high for the single cycle after its edge. Samples with `hs_cur` = 175 and `ls_cur` = 127 do not.
- R8: Short detection is masked for samples taken in the strobe cycle of `edge_stb` and in the following BLANK_CYC = CLK_MHZ*16500/1000 cycles. Each new strobe restarts the window.
- R9: After each valid sample, `ot_req` equals (temperature code > 175) and holds that value until the next valid sample.
- R10: When `samp_valid` is low, the sample inputs have no effect: no limit event, no short request, and `ot_req` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Qualifies the sample inputs in this cycle; always accepted |
| hs_cur | input | CUR_W | High-side current code, 1/16 A per LSB |
| ls_cur | input | CUR_W | Low-side current code, 1/16 A per LSB |
| temp_code | input | TEMP_W | Junction temperature code, 1 °C per LSB |
| edge_stb | input | 1 | Pulses in a cycle where the bridge output transitions |
| force_off | output | 1 | High while the off-time after a limit event is running |
| short_req | output | 1 | One-cycle hard-short latch request |
| ot_req | output | 1 | Overtemperature shutdown request |

## Verification
A sample taken at edge k shows its effect right after that edge. `short_req`, `ot_req` and the rise of `force_off` can all be seen half a cycle later. The bench drives inputs on falling edges and samples outputs on the next falling edge, one register stage after the edge that captured the stimulus. Off-time length and event spacing are measured by counting falling edges from the triggering sample. The blanking window is checked by placing a short sample at each offset from 0 to BLANK_CYC+2 after a fresh strobe.

// File: rtl/hbcl_pkg.sv
package hbcl_pkg;
  // Converts a duration in nanoseconds into a cycle count at a clock of mhz MHz.
  function automatic int unsigned ns_to_cyc(int unsigned mhz, int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction
endpackage

// File: rtl/hbcl_fold.sv
module hbcl_fold #(
  parameter int CUR_W  = 8,
  parameter int TEMP_W = 8,
  parameter int NOM    = 104,
  parameter int FLOOR  = 40,
  parameter int T_KNEE = 160,
  parameter int T_END  = 175
) (
  input  logic [TEMP_W-1:0] temp_code,
  output logic [CUR_W-1:0]  thr
);
  localparam int P_W  = CUR_W + TEMP_W;
  localparam int SPAN = T_END - T_KNEE;
  localparam int DROP = NOM - FLOOR;

  logic [TEMP_W-1:0] dt;
  logic [P_W-1:0]    prod;
  logic [P_W-1:0]    quot;

  always_comb begin
    dt   = temp_code - TEMP_W'(T_KNEE);
    prod = P_W'(DROP) * P_W'(dt);
    quot = prod / P_W'(SPAN);
    if (temp_code <= TEMP_W'(T_KNEE))
      thr = CUR_W'(NOM);
    else if (temp_code >= TEMP_W'(T_END))
      thr = CUR_W'(FLOOR);
    else
      thr = CUR_W'(NOM) - CUR_W'(quot);
  end
endmodule

// File: rtl/hbcl_offtimer.sv
module hbcl_offtimer #(
  parameter int unsigned OFF_CYC = 2000,
  parameter int unsigned PER_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic force_off
);
  localparam int CW = $clog2(PER_CYC + 1);

  logic [CW-1:0] off_cnt;
  logic [CW-1:0] per_cnt;
  logic          accept;

  assign accept = fire && (off_cnt == '0) && (per_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= '0;
      per_cnt <= '0;
    end else if (accept) begin
      off_cnt <= CW'(OFF_CYC);
      per_cnt <= CW'(PER_CYC - 1);
    end else begin
      if (off_cnt != '0) off_cnt <= off_cnt - 1'b1;
      if (per_cnt != '0) per_cnt <= per_cnt - 1'b1;
    end
  end

  assign force_off = (off_cnt != '0);
endmodule

// File: rtl/hbcl_blank.sv
module hbcl_blank #(
  parameter int CUR_W             = 8,
  parameter int unsigned BLANK_CYC = 1650,
  parameter int SC_HS             = 176,
  parameter int SC_LS             = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_stb,
  input  logic             samp_valid,
  input  logic [CUR_W-1:0] hs_cur,
  input  logic [CUR_W-1:0] ls_cur,
  output logic             short_req
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] blank_cnt;
  logic          masked;
  logic          hard;

  assign masked = edge_stb || (blank_cnt != '0);
  assign hard   = (hs_cur >= CUR_W'(SC_HS)) || (ls_cur >= CUR_W'(SC_LS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      short_req <= 1'b0;
    end else begin
      if (edge_stb)               blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)   blank_cnt <= blank_cnt - 1'b1;
      short_req <= samp_valid && !masked && hard;
    end
  end
endmodule

// File: rtl/hb_current_limiter.sv
module hb_current_limiter #(
  parameter int CUR_W          = 8,
  parameter int TEMP_W         = 8,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned OFF_NS   = 20000,
  parameter int unsigned BLANK_NS = 16500,
  parameter int unsigned PER_NS   = 50000,
  parameter int LIM_NOM        = 104,
  parameter int LIM_FLOOR      = 40,
  parameter int T_KNEE         = 160,
  parameter int T_END          = 175,
  parameter int SC_HS          = 176,
  parameter int SC_LS          = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [CUR_W-1:0]  hs_cur,
  input  logic [CUR_W-1:0]  ls_cur,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              edge_stb,
  output logic              force_off,
  output logic              short_req,
  output logic              ot_req
);
  localparam int unsigned OFF_CYC   = hbcl_pkg::ns_to_cyc(CLK_MHZ, OFF_NS);
  localparam int unsigned BLANK_CYC = hbcl_pkg::ns_to_cyc(CLK_MHZ, BLANK_NS);
  localparam int unsigned PER_CYC   = hbcl_pkg::ns_to_cyc(CLK_MHZ, PER_NS);

  logic [CUR_W-1:0] thr;
  logic             fire;

  hbcl_fold #(
    .CUR_W(CUR_W), .TEMP_W(TEMP_W), .NOM(LIM_NOM), .FLOOR(LIM_FLOOR),
    .T_KNEE(T_KNEE), .T_END(T_END)
  ) u_fold (
    .temp_code(temp_code),
    .thr(thr)
  );

  assign fire = samp_valid && (hs_cur >= thr);

  hbcl_offtimer #(.OFF_CYC(OFF_CYC), .PER_CYC(PER_CYC)) u_off (
    .clk(clk), .rst_n(rst_n), .fire(fire), .force_off(force_off)
  );

  hbcl_blank #(
    .CUR_W(CUR_W), .BLANK_CYC(BLANK_CYC), .SC_HS(SC_HS), .SC_LS(SC_LS)
  ) u_blank (
    .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .samp_valid(samp_valid),
    .hs_cur(hs_cur), .ls_cur(ls_cur), .short_req(short_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ot_req <= 1'b0;
    else if (samp_valid) ot_req <= (temp_code > TEMP_W'(T_END));
  end
endmodule

// File: rtl/hbcl_checker.sv
module hbcl_checker #(
  parameter int CUR_W          = 8,
  parameter int TEMP_W         = 8,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned OFF_NS   = 20000,
  parameter int unsigned PER_NS   = 50000,
  parameter int T_END          = 175,
  parameter int SC_HS          = 176,
  parameter int SC_LS          = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_valid,
  input logic [CUR_W-1:0]  hs_cur,
  input logic [CUR_W-1:0]  ls_cur,
  input logic [TEMP_W-1:0] temp_code,
  input logic              edge_stb,
  input logic              force_off,
  input logic              short_req,
  input logic              ot_req
);
  localparam int unsigned OFF_CYC = hbcl_pkg::ns_to_cyc(CLK_MHZ, OFF_NS);
  localparam int unsigned PER_CYC = hbcl_pkg::ns_to_cyc(CLK_MHZ, PER_NS);
  localparam int CW = $clog2(PER_CYC + 2);

  logic [CW-1:0] run_len;
  logic [CW-1:0] gap;
  logic          fo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      gap     <= CW'(PER_CYC);
      fo_q    <= 1'b0;
    end else begin
      fo_q <= force_off;
      if (force_off) run_len <= (run_len == CW'(PER_CYC)) ? run_len : run_len + 1'b1;
      else           run_len <= '0;
      if (force_off && !fo_q)       gap <= CW'(1);
      else if (gap != CW'(PER_CYC)) gap <= gap + 1'b1;
    end
  end

  assert_off_not_longer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (run_len < CW'(OFF_CYC)));
  assert_off_exact_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_off && fo_q) |-> (run_len == CW'(OFF_CYC)));
  assert_event_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off && !fo_q) |-> (gap >= CW'(PER_CYC)));
  assert_no_short_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cur < CUR_W'(SC_HS) && ls_cur < CUR_W'(SC_LS)) |=> !short_req);
  assert_strobe_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> !short_req);
  assert_ot_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |=> (ot_req == ($past(temp_code) > TEMP_W'(T_END))));
  assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> ($stable(ot_req) && !short_req));
endmodule

bind hb_current_limiter hbcl_checker #(
  .CUR_W(CUR_W), .TEMP_W(TEMP_W), .CLK_MHZ(CLK_MHZ), .OFF_NS(OFF_NS),
  .PER_NS(PER_NS), .T_END(T_END), .SC_HS(SC_HS), .SC_LS(SC_LS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .hs_cur(hs_cur),
  .ls_cur(ls_cur), .temp_code(temp_code), .edge_stb(edge_stb),
  .force_off(force_off), .short_req(short_req), .ot_req(ot_req)
);

// File: tb/test_hb_current_limiter.sv
module test_hb_current_limiter;
  localparam int OFF   = 20;
  localparam int BLANK = 16;
  localparam int PER   = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_valid = 1'b0;
  logic [7:0] hs_cur = '0;
  logic [7:0] ls_cur = '0;
  logic [7:0] temp_code = '0;
  logic       edge_stb = 1'b0;
  logic       force_off, short_req, ot_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_current_limiter #(.CLK_MHZ(1)) i_hb_current_limiter (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .hs_cur(hs_cur),
    .ls_cur(ls_cur), .temp_code(temp_code), .edge_stb(edge_stb),
    .force_off(force_off), .short_req(short_req), .ot_req(ot_req)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(bit v, int hs, int ls, int t, bit stb);
    samp_valid = v;
    hs_cur     = 8'(hs);
    ls_cur     = 8'(ls);
    temp_code  = 8'(t);
    edge_stb   = stb;
    @(negedge clk);
    samp_valid = 1'b0;
    edge_stb   = 1'b0;
    hs_cur     = '0;
    ls_cur     = '0;
  endtask

  function automatic int exp_thr(int t);
    if (t <= 160) return 104;
    if (t >= 175) return 40;
    return 104 - (64 * (t - 160)) / 15;
  endfunction

  initial begin
    int cnt;
    tick(3);
    chk("R1 force_off in reset", int'(force_off), 0);
    chk("R1 short_req in reset", int'(short_req), 0);
    chk("R1 ot_req in reset", int'(ot_req), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 outputs after release", int'({force_off, short_req, ot_req}), 0);

    // R2 / R3 / R9: threshold sweep over temperature
    for (int t = 150; t <= 180; t++) begin
      for (int d = -2; d <= 1; d++) begin
        int hs;
        hs = exp_thr(t) + d;
        tick(PER + 5);
        apply(1, hs, 0, t, 0);
        if (t <= 160) chk($sformatf("R2 limit t=%0d hs=%0d", t, hs), int'(force_off), int'(d >= 0));
        else          chk($sformatf("R3 limit t=%0d hs=%0d", t, hs), int'(force_off), int'(d >= 0));
        chk($sformatf("R9 ot t=%0d", t), int'(ot_req), int'(t > 175));
      end
    end

    // R4 / R5: off-time length with an extra over-limit sample inside it
    tick(PER + 5);
    apply(1, 120, 0, 25, 0);
    cnt = int'(force_off);
    for (int i = 1; i <= 40; i++) begin
      if (i == 5) apply(1, 120, 0, 25, 0);
      else        tick(1);
      if (force_off) cnt++;
    end
    chk("R4 off-time length", cnt, OFF);
    chk("R5 no extension from mid-interval event", int'(force_off), 0);

    // R6: minimum spacing between accepted events
    tick(PER + 5);
    apply(1, 120, 0, 25, 0);
    chk("R6 first event", int'(force_off), 1);
    tick(PER - 2);
    apply(1, 120, 0, 25, 0);
    chk("R6 event at PER-1 ignored", int'(force_off), 0);
    apply(1, 120, 0, 25, 0);
    chk("R6 event at PER accepted", int'(force_off), 1);

    // R7: hard-short thresholds
    tick(PER + 5);
    apply(1, 176, 0, 25, 0);
    chk("R7 hs at threshold", int'(short_req), 1);
    tick(1);
    chk("R7 single-cycle pulse", int'(short_req), 0);
    apply(1, 175, 0, 25, 0);
    chk("R7 hs below threshold", int'(short_req), 0);
    apply(1, 0, 128, 25, 0);
    chk("R7 ls at threshold", int'(short_req), 1);
    apply(1, 0, 127, 25, 0);
    chk("R7 ls below threshold", int'(short_req), 0);

    // R8: blanking offsets after a fresh strobe
    apply(1, 0, 200, 25, 1);
    chk("R8 sample in strobe cycle", int'(short_req), 0);
    for (int m = 1; m <= BLANK + 2; m++) begin
      apply(0, 0, 0, 25, 1);
      tick(m - 1);
      apply(1, 0, 200, 25, 0);
      chk($sformatf("R8 offset %0d", m), int'(short_req), int'(m > BLANK));
    end

    // R10: invalid samples ignored
    tick(PER + 5);
    apply(0, 200, 200, 200, 0);
    chk("R10 no force on invalid", int'(force_off), 0);
    chk("R10 no short on invalid", int'(short_req), 0);
    chk("R10 ot kept low", int'(ot_req), 0);
    apply(1, 0, 0, 180, 0);
    chk("R9 ot set", int'(ot_req), 1);
    apply(0, 0, 0, 25, 0);
    chk("R10 ot kept high", int'(ot_req), 1);
    apply(1, 0, 0, 175, 0);
    chk("R9 ot clear at 175", int'(ot_req), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule